// File: doc/BRIEF.md
# Audio Codec DMA Byte Sequencer

This block is the device side of an 8-bit DMA link between a host bus and an audio codec. The codec has two directions: capture, where the host reads samples, and playback, where the host writes them. On each internal sample-period tick, every enabled direction raises a request. It then moves one sample frame, one byte at a time. A byte is done when the host ends a read or write strobe while the acknowledge is held. A frame is 1, 2 or 4 bytes, depending on the selected format (8 or 16 bits, mono or stereo). Bytes always go out in a fixed order.

The block drives the data-buffer enable and direction outputs during acknowledged strobes. Each direction has a down-counter that is loaded from a programmable base value. The counter decrements once per finished frame. When it underflows, it sets a sticky host interrupt and reloads from the base value. In single-channel mode, capture traffic is moved onto the playback request and acknowledge pins.

Top module: `codec_dma_seq`

## Requirements
- R1: After reset, cap_req, play_req, irq, host_doe, buf_en, buf_dir and play_done are low, and host_dout is zero.
- R2: A direction's request rises in the cycle after an edge that sees sample_tick high while that direction is enabled and has no request pending. A tick seen while the direction is disabled raises nothing.
- R3: The frame length is set by fmt: 00 (8-bit mono) is 1 byte, 01 (8-bit stereo) is 2, 10 (16-bit mono) is 2, and 11 (16-bit stereo) is 4. A byte ends at the edge that sees its strobe (host_rd_n or host_wr_n) return high after being low, with the acknowledge high. The request stays high through the earlier bytes and drops after the edge that ends the final byte.
- R4: Capture byte order comes from left/right sample words snapshotted when the request rises. For fmt 11 it is left low, left high, right low, right high. For fmt 01 it is left low, then right low. For fmt 10 it is left low, then left high. For fmt 00 it is left low.
- R5: Playback bytes are taken from host_din at the end of each acknowledged write strobe. They are placed into play_left/play_right in the R4 order. In 8-bit formats the upper byte of the word written is cleared. play_done pulses for one cycle after the final byte.
- R6: A strobe that ends while the acknowledge is low has no effect. The byte position does not advance and the bus is not driven.
- R7: host_doe is high only while the capture request, its acknowledge and host_rd_n low all hold together. host_dout is zero whenever host_doe is low.
- R8: buf_en is high during any acknowledged strobe of a pending request. buf_dir is high only for a playback write and low for a capture read.
- R9: With single_chan high, the capture request appears on play_req, capture takes its acknowledge from play_ack, and cap_req stays low. While capture is enabled in this mode, the playback direction is held idle.
- R10: Each direction's count loads base_count while the direction is disabled and decrements once per finished frame. A frame that finishes with the count at zero sets irq and reloads base_count, so irq rises after base_count+1 frames.
- R11: irq stays high until int_clr is seen. An underflow in the same cycle as int_clr takes priority.
- R12: A change of fmt returns the byte position to the first byte of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Internal sample-period tick, one cycle |
| cap_en | input | 1 | Capture direction enable |
| play_en | input | 1 | Playback direction enable |
| single_chan | input | 1 | Route capture onto the playback pins |
| fmt | input | 2 | Frame format: bit 0 stereo, bit 1 16-bit |
| base_count | input | CNT_W | Frames per interrupt minus one |
| int_clr | input | 1 | Clears the interrupt |
| cap_ack | input | 1 | Capture acknowledge, active high |
| play_ack | input | 1 | Playback acknowledge, active high |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | BYTE_W | Host write data |
| cap_left | input | 2*BYTE_W | Capture left (or mono) sample |
| cap_right | input | 2*BYTE_W | Capture right sample |
| cap_req | output | 1 | Capture request |
| play_req | output | 1 | Playback request (or capture in single-channel mode) |
| host_dout | output | BYTE_W | Host read data |
| host_doe | output | 1 | Host read data drive enable |
| buf_en | output | 1 | Data-buffer enable |
| buf_dir | output | 1 | Data-buffer direction, high for playback |
| irq | output | 1 | Host interrupt |
| play_done | output | 1 | Pulse after a playback frame completes |
| play_left | output | 2*BYTE_W | Assembled playback left sample |
| play_right | output | 2*BYTE_W | Assembled playback right sample |

## Verification
The bench attacks the 16-bit stereo ordering. A design that swaps the stereo and width index bits would return the right low byte second instead of the left high byte. A strobe pulsed with no acknowledge is sent between frames. A design that advances on bare strobes would skip the left byte of the next 8-bit stereo frame.

The format is switched in the middle of a frame to catch a stale byte position. Without the reset, the new 16-bit mono frame would start on its high byte and never end its request cleanly. The interrupt is expected exactly on the third frame with a base count of two, which catches off-by-one underflow logic. Single-channel mode is checked to confirm that capture moves to the playback pins and leaves the capture request silent.

// File: rtl/codec_dma_pkg.sv
package codec_dma_pkg;

  localparam int MAX_BYTES = 4;
  localparam int IDX_W     = $clog2(MAX_BYTES);

  typedef enum logic [1:0] {
    FMT_MONO8    = 2'b00,
    FMT_STEREO8  = 2'b01,
    FMT_MONO16   = 2'b10,
    FMT_STEREO16 = 2'b11
  } frame_fmt_e;

  // Number of bytes that make up one sample frame.
  function automatic logic [IDX_W:0] frame_bytes(frame_fmt_e f);
    case (f)
      FMT_MONO8:    frame_bytes = 3'd1;
      FMT_STEREO8:  frame_bytes = 3'd2;
      FMT_MONO16:   frame_bytes = 3'd2;
      default:      frame_bytes = 3'd4;
    endcase
  endfunction

  // Byte k of the frame belongs to the right sample word.
  function automatic logic byte_is_right(frame_fmt_e f, logic [IDX_W-1:0] k);
    case (f)
      FMT_STEREO8:  byte_is_right = k[0];
      FMT_STEREO16: byte_is_right = k[1];
      default:      byte_is_right = 1'b0;
    endcase
  endfunction

  // Byte k of the frame is the upper half of its sample word.
  function automatic logic byte_is_high(frame_fmt_e f, logic [IDX_W-1:0] k);
    case (f)
      FMT_MONO16, FMT_STEREO16: byte_is_high = k[0];
      default:                  byte_is_high = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_frame_seq.sv
module dma_frame_seq
  import codec_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             ack,
  input  logic             strobe_n,
  input  frame_fmt_e       fmt,
  input  logic             fmt_chg,
  output logic             req,
  output logic [IDX_W-1:0] idx,
  output logic             start,
  output logic             byte_done,
  output logic             frame_done,
  output logic             active
);

  logic strb_q;
  logic at_last;

  assign start      = en & tick & ~req;
  assign byte_done  = req & ack & ~strb_q & strobe_n;
  assign at_last    = ({1'b0, idx} == frame_bytes(fmt) - 1'b1);
  assign frame_done = byte_done & at_last;
  assign active     = req & ack & ~strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      idx    <= '0;
      strb_q <= 1'b1;
    end else begin
      strb_q <= strobe_n;
      if (!en) begin
        req <= 1'b0;
        idx <= '0;
      end else begin
        if (fmt_chg || frame_done) idx <= '0;
        else if (byte_done)        idx <= idx + 1'b1;
        if (frame_done)   req <= 1'b0;
        else if (start)   req <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_count_irq.sv
module dma_count_irq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] base,
  input  logic             frame_done,
  output logic             underflow
);

  logic [CNT_W-1:0] count;

  assign underflow = en & frame_done & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (!en)        count <= base;
    else if (frame_done) count <= (count == '0) ? base : count - 1'b1;
  end

endmodule

// File: rtl/codec_dma_seq.sv
module codec_dma_seq
  import codec_dma_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_tick,
  input  logic                cap_en,
  input  logic                play_en,
  input  logic                single_chan,
  input  logic [1:0]          fmt,
  input  logic [CNT_W-1:0]    base_count,
  input  logic                int_clr,
  input  logic                cap_ack,
  input  logic                play_ack,
  input  logic                host_rd_n,
  input  logic                host_wr_n,
  input  logic [BYTE_W-1:0]   host_din,
  input  logic [2*BYTE_W-1:0] cap_left,
  input  logic [2*BYTE_W-1:0] cap_right,
  output logic                cap_req,
  output logic                play_req,
  output logic [BYTE_W-1:0]   host_dout,
  output logic                host_doe,
  output logic                buf_en,
  output logic                buf_dir,
  output logic                irq,
  output logic                play_done,
  output logic [2*BYTE_W-1:0] play_left,
  output logic [2*BYTE_W-1:0] play_right
);

  localparam int NCH    = 2;   // 0 = capture, 1 = playback
  localparam int SAMP_W = 2 * BYTE_W;

  frame_fmt_e       fmt_cur, fmt_q;
  logic             fmt_chg;
  logic             cap_shared;

  logic [NCH-1:0]   ch_en, ch_ack, ch_strb_n;
  logic [NCH-1:0]   ch_req, ch_start, ch_byte_done, ch_frame_done, ch_active, ch_underflow;
  logic [IDX_W-1:0] ch_idx [NCH];

  logic [SAMP_W-1:0] snap_l, snap_r, cap_word;
  logic              cap_right_sel, cap_high_sel, wr_right_sel, wr_high_sel;

  assign fmt_cur    = frame_fmt_e'(fmt);
  assign fmt_chg    = (fmt_cur != fmt_q);
  assign cap_shared = single_chan & cap_en;

  // Pin routing: single-channel mode moves capture onto the playback pins.
  assign ch_en[0]     = cap_en;
  assign ch_en[1]     = play_en & ~cap_shared;
  assign ch_ack[0]    = single_chan ? play_ack : cap_ack;
  assign ch_ack[1]    = play_ack & ~cap_shared;
  assign ch_strb_n[0] = host_rd_n;
  assign ch_strb_n[1] = host_wr_n;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_frame_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ch_en[c]),
      .tick       (sample_tick),
      .ack        (ch_ack[c]),
      .strobe_n   (ch_strb_n[c]),
      .fmt        (fmt_cur),
      .fmt_chg    (fmt_chg),
      .req        (ch_req[c]),
      .idx        (ch_idx[c]),
      .start      (ch_start[c]),
      .byte_done  (ch_byte_done[c]),
      .frame_done (ch_frame_done[c]),
      .active     (ch_active[c])
    );

    dma_count_irq #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ch_en[c]),
      .base       (base_count),
      .frame_done (ch_frame_done[c]),
      .underflow  (ch_underflow[c])
    );
  end

  assign cap_req  = ch_req[0] & ~single_chan;
  assign play_req = ch_req[1] | (ch_req[0] & single_chan);
  assign buf_en   = |ch_active;
  assign buf_dir  = ch_active[1];

  // Capture: byte selected from the frame snapshot.
  assign cap_right_sel = byte_is_right(fmt_cur, ch_idx[0]);
  assign cap_high_sel  = byte_is_high(fmt_cur, ch_idx[0]);
  assign cap_word      = cap_right_sel ? snap_r : snap_l;
  assign host_doe      = ch_active[0];
  assign host_dout     = !host_doe     ? '0 :
                         cap_high_sel  ? cap_word[SAMP_W-1:BYTE_W] :
                                         cap_word[BYTE_W-1:0];

  // Playback: byte placement.
  assign wr_right_sel = byte_is_right(fmt_cur, ch_idx[1]);
  assign wr_high_sel  = byte_is_high(fmt_cur, ch_idx[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q      <= FMT_MONO8;
      snap_l     <= '0;
      snap_r     <= '0;
      play_left  <= '0;
      play_right <= '0;
      play_done  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      fmt_q     <= fmt_cur;
      play_done <= ch_frame_done[1];
      if (ch_start[0]) begin
        snap_l <= cap_left;
        snap_r <= cap_right;
      end
      if (ch_byte_done[1]) begin
        if (wr_right_sel) begin
          if (wr_high_sel)      play_right[SAMP_W-1:BYTE_W] <= host_din;
          else if (fmt_cur[1])  play_right[BYTE_W-1:0]      <= host_din;
          else                  play_right <= {{BYTE_W{1'b0}}, host_din};
        end else begin
          if (wr_high_sel)      play_left[SAMP_W-1:BYTE_W]  <= host_din;
          else if (fmt_cur[1])  play_left[BYTE_W-1:0]       <= host_din;
          else                  play_left <= {{BYTE_W{1'b0}}, host_din};
        end
      end
      if (|ch_underflow) irq <= 1'b1;
      else if (int_clr)  irq <= 1'b0;
    end
  end

endmodule

// File: rtl/codec_dma_seq_chk.sv
module codec_dma_seq_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sample_tick,
  input logic           single_chan,
  input logic           int_clr,
  input logic           host_rd_n,
  input logic           cap_req,
  input logic           host_doe,
  input logic           buf_en,
  input logic           buf_dir,
  input logic           irq,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ch_req,
  input logic [NCH-1:0] ch_frame_done,
  input logic [NCH-1:0] ch_underflow
);

  for (genvar c = 0; c < NCH; c++) begin : g_chan_props
    // R2: a request only starts on a sample tick
    p_req_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_req[c]) |-> $past(sample_tick));

    // R3: a request only ends with its final byte or a disable
    p_req_end_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_req[c]) |-> ($past(ch_frame_done[c]) || $past(!ch_en[c])));
  end

  p_doe_needs_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> !host_rd_n);

  p_dir_within_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_dir |-> buf_en);

  p_no_capreq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    single_chan |-> !cap_req);

  p_irq_from_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|ch_underflow));

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !int_clr) |=> irq);

endmodule

bind codec_dma_seq codec_dma_seq_chk #(.NCH(2)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sample_tick   (sample_tick),
  .single_chan   (single_chan),
  .int_clr       (int_clr),
  .host_rd_n     (host_rd_n),
  .cap_req       (cap_req),
  .host_doe      (host_doe),
  .buf_en        (buf_en),
  .buf_dir       (buf_dir),
  .irq           (irq),
  .ch_en         (ch_en),
  .ch_req        (ch_req),
  .ch_frame_done (ch_frame_done),
  .ch_underflow  (ch_underflow)
);

// File: tb/codec_dma_seq_tb_top.sv
`timescale 1ns/1ps
module codec_dma_seq_tb_top;

  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_tick = 0, cap_en = 0, play_en = 0, single_chan = 0, int_clr = 0;
  logic [1:0]  fmt = 2'b00;
  logic [15:0] base_count = 16'd2;
  logic        cap_ack = 0, play_ack = 0, host_rd_n = 1, host_wr_n = 1;
  logic [7:0]  host_din = 8'h00;
  logic [15:0] cap_left = 16'hA1B2, cap_right = 16'hC3D4;
  logic        cap_req, play_req, host_doe, buf_en, buf_dir, irq, play_done;
  logic [7:0]  host_dout;
  logic [15:0] play_left, play_right;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  codec_dma_seq #(.CNT_W(CNT_W), .BYTE_W(8)) dut_i (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_req[2], m_idx[2], m_sq[2], m_cnt[2], m_fmtq;
  bit m_irq, m_pdone;
  logic [15:0] m_snl, m_snr;
  logic [7:0]  pb[4];   // 0 left low, 1 left high, 2 right low, 3 right high

  function automatic int flen(int f);
    return (f % 2 + 1) * (f / 2 + 1);
  endfunction

  function automatic int fpos(int f, int i);
    case (f)
      0: return 0;
      1: return 2 * i;
      default: return i;
    endcase
  endfunction

  function automatic bit m_run(int c);
    if (c == 0) return cap_en;
    return play_en && !(single_chan && cap_en);
  endfunction

  function automatic bit m_ack(int c);
    if (c == 0) return single_chan ? play_ack : cap_ack;
    return play_ack && !(single_chan && cap_en);
  endfunction

  function automatic bit m_strb(int c);
    return (c == 0) ? host_rd_n : host_wr_n;
  endfunction

  function automatic logic [7:0] snap_byte(int p);
    case (p)
      0: return m_snl[7:0];
      1: return m_snl[15:8];
      2: return m_snr[7:0];
      default: return m_snr[15:8];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_req[c] = 0; m_idx[c] = 0; m_sq[c] = 1; m_cnt[c] = 0;
      end
      m_fmtq = 0; m_irq = 0; m_pdone = 0; m_snl = 0; m_snr = 0;
      for (int k = 0; k < 4; k++) pb[k] = 8'h00;
    end else begin
      bit und, chg;
      und = 0;
      chg = (int'(fmt) != m_fmtq);
      for (int c = 0; c < 2; c++) begin
        bit done, last, run;
        int p;
        run  = m_run(c);
        done = m_req[c] != 0 && m_ack(c) && m_sq[c] == 0 && m_strb(c);
        last = (m_idx[c] == flen(fmt) - 1);
        if (c == 1) begin
          if (done) begin
            p = fpos(fmt, m_idx[1]);
            pb[p] = host_din;
            if (fmt < 2) pb[p + 1] = 8'h00;
          end
          m_pdone = done && last;
        end
        if (c == 0 && run && sample_tick && m_req[0] == 0) begin
          m_snl = cap_left; m_snr = cap_right;
        end
        if (!run) m_cnt[c] = base_count;
        else if (done && last) begin
          if (m_cnt[c] == 0) begin m_cnt[c] = base_count; und = 1; end
          else m_cnt[c]--;
        end
        m_sq[c] = m_strb(c);
        if (!run) begin
          m_req[c] = 0; m_idx[c] = 0;
        end else begin
          if (chg || (done && last)) m_idx[c] = 0;
          else if (done) m_idx[c]++;
          if (done && last) m_req[c] = 0;
          else if (sample_tick) m_req[c] = 1;
        end
      end
      if (und) m_irq = 1;
      else if (int_clr) m_irq = 0;
      m_fmtq = fmt;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit a0, a1;
      logic [7:0] exp_dout;
      a0 = m_req[0] != 0 && m_ack(0) && !host_rd_n;
      a1 = m_req[1] != 0 && m_ack(1) && !host_wr_n;
      exp_dout = a0 ? snap_byte(fpos(fmt, m_idx[0])) : 8'h00;
      chk("R2", "cap_req",  cap_req,  m_req[0] != 0 && !single_chan);
      chk("R9", "play_req", play_req, m_req[1] != 0 || (single_chan && m_req[0] != 0));
      chk("R10", "irq",     irq,      m_irq);
      chk("R7", "host_doe", host_doe, a0);
      chk("R4", "host_dout", host_dout, exp_dout);
      chk("R8", "buf_en",   buf_en,   a0 || a1);
      chk("R8", "buf_dir",  buf_dir,  a1);
      chk("R5", "play_done", play_done, m_pdone);
      chk("R5", "play_left",  play_left,  {pb[1], pb[0]});
      chk("R5", "play_right", play_right, {pb[3], pb[2]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_tick();
    sample_tick = 1; step(); sample_tick = 0; step();
  endtask

  task automatic set_ack(bit use_play_pin, bit v);
    if (use_play_pin) play_ack = v; else cap_ack = v;
  endtask

  task automatic rd_byte(bit use_play_pin, output logic [7:0] got);
    set_ack(use_play_pin, 1); step();
    host_rd_n = 0; step();
    @(negedge clk); got = host_dout;
    @(posedge clk); #1;
    host_rd_n = 1; step();
    set_ack(use_play_pin, 0); step();
  endtask

  task automatic wr_byte(logic [7:0] d);
    play_ack = 1; step();
    host_wr_n = 0; host_din = d; step();
    host_wr_n = 1; step();
    play_ack = 0; step();
  endtask

  task automatic finish_sim();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      finish_sim();
    end
  end

  initial begin
    logic [7:0] b0, b1, b2, b3;
    step(3);
    rst_n = 1;
    step();
    // R1: reset state
    chk("R1", "cap_req", cap_req, 0);
    chk("R1", "play_req", play_req, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "buf_en/doe/dir", {buf_en, host_doe, buf_dir, play_done}, 0);
    chk("R1", "host_dout", host_dout, 0);

    // 16-bit stereo capture; playback disabled
    fmt = 2'b11; cap_en = 1; step(2);
    pulse_tick();
    chk("R2", "play_req with playback off", play_req, 0);
    chk("R2", "cap_req after tick", cap_req, 1);
    rd_byte(0, b0); rd_byte(0, b1); rd_byte(0, b2);
    chk("R3", "cap_req held before last byte", cap_req, 1);
    rd_byte(0, b3);
    chk("R3", "cap_req dropped after 4th byte", cap_req, 0);
    chk("R4", "stereo16 order", {b0, b1, b2, b3}, 32'hB2A1D4C3);
    chk("R10", "irq after frame 1", irq, 0);

    // R6: strobe without acknowledge, then 8-bit stereo frame
    fmt = 2'b01; step();
    pulse_tick();
    host_rd_n = 0; step(2); host_rd_n = 1; step(2);
    chk("R6", "cap_req after bare strobe", cap_req, 1);
    rd_byte(0, b0); rd_byte(0, b1);
    chk("R6", "stereo8 first byte unaffected", b0, 8'hB2);
    chk("R4", "stereo8 second byte", b1, 8'hD4);
    chk("R3", "cap_req dropped after 2nd byte", cap_req, 0);
    chk("R10", "irq after frame 2", irq, 0);

    // 8-bit mono frame -> third frame underflows (base 2)
    fmt = 2'b00; step();
    pulse_tick();
    rd_byte(0, b0);
    chk("R4", "mono8 byte", b0, 8'hB2);
    chk("R3", "cap_req dropped after 1 byte", cap_req, 0);
    chk("R10", "irq on third frame", irq, 1);
    step(3);
    chk("R11", "irq held", irq, 1);
    int_clr = 1; step(); int_clr = 0; step();
    chk("R11", "irq cleared", irq, 0);

    // R12: format change mid-frame
    fmt = 2'b11; step();
    pulse_tick();
    rd_byte(0, b0);
    fmt = 2'b10; step();
    rd_byte(0, b1);
    chk("R12", "byte after format change", b1, 8'hB2);
    chk("R3", "cap_req held in mono16", cap_req, 1);
    rd_byte(0, b2);
    chk("R12", "mono16 high byte", b2, 8'hA1);
    chk("R3", "cap_req dropped after mono16", cap_req, 0);

    // playback
    cap_en = 0; play_en = 1; fmt = 2'b11; step(2);
    pulse_tick();
    chk("R2", "play_req after tick", play_req, 1);
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44);
    chk("R5", "stereo16 left", play_left, 16'h2211);
    chk("R5", "stereo16 right", play_right, 16'h4433);
    chk("R3", "play_req dropped", play_req, 0);
    fmt = 2'b01; step();
    pulse_tick();
    wr_byte(8'h55); wr_byte(8'h66);
    chk("R5", "stereo8 left", play_left, 16'h0055);
    chk("R5", "stereo8 right", play_right, 16'h0066);

    // R9: single-channel mode
    play_en = 0; single_chan = 1; cap_en = 1; fmt = 2'b00;
    cap_left = 16'h5A7E; step(2);
    pulse_tick();
    chk("R9", "cap_req silent", cap_req, 0);
    chk("R9", "capture on play_req", play_req, 1);
    rd_byte(1, b0);
    chk("R9", "byte via playback ack", b0, 8'h7E);
    chk("R9", "play_req dropped", play_req, 0);

    step(4);
    finish_sim();
  end

endmodule